// File: doc/BRIEF.md
# Object Attribute Copy Engine

This block fills the 160-byte object attribute memory of a display subsystem from any page of the system address space, with no work from the processor after one register write. Writing an 8-bit page value starts a transfer from the 16-bit address formed by that page in the upper byte and zero in the lower byte. The engine then moves one byte per copy slot. It reads the system bus at the current source address and writes the returned byte into attribute memory at the current index, in the same cycle.

The first copy slot comes after a fixed start delay. Later slots follow at a fixed, shorter spacing. A page whose base would run past the top of the usable source space is refused. A valid page written during a transfer abandons the old one and starts over from the new base.

The busy output and the read address together tell the surrounding address decoder which source region is being used. The decoder can then block processor accesses that conflict with the transfer. The engine's own reads are not gated by that blocking.

Top module: `oam_copy_engine`

## Requirements
- R1: A start with a page value above 0xF1 (a base above 0xF100) is ignored: busy and all transfer state stay unchanged. Page 0xF1 itself is accepted.
- R2: On an accepted start, the source address loads `{page, 8'h00}`, the destination index clears to 0 and 160 bytes become pending. All of this is visible in the cycle after the start edge.
- R3: The first byte is written at the 8th rising edge after the edge that samples the start. The write strobe is high during the cycle that ends at that edge.
- R4: Each later byte is written 4 edges after the previous one.
- R5: A copy cycle drives `rd_en_o` and `wr_en_o` high together. `rd_addr_o` is base + k, `wr_addr_o` is k, and `wr_data_o` equals `rd_data_i` in that same cycle. Source and index both step by one after the copy.
- R6: After the 160th byte (index 159) no further copy happens.
- R7: An accepted start during a transfer restarts it from the new base with index 0 and the full start delay.
- R8: `busy_o` is high from the cycle after an accepted start through the cycle of the last copy, and is low otherwise. No write occurs while it is low.
- R9: When an accepted start falls in a copy cycle, that copy is dropped (no strobe). A refused start in a copy cycle does not disturb the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request strobe |
| page_i | input | 8 | Source page (upper address byte) with the start |
| rd_en_o | output | 1 | Bus read strobe, high in copy cycles |
| rd_addr_o | output | 16 | Current source address |
| rd_data_i | input | 8 | Byte returned by the bus in the same cycle |
| wr_en_o | output | 1 | Attribute memory write strobe |
| wr_addr_o | output | 8 | Attribute memory index |
| wr_data_o | output | 8 | Byte written into attribute memory |
| busy_o | output | 1 | Transfer in progress |

## Verification
A start request and a byte copy can land in the same cycle. The bench provokes this by counting edges from a known start and driving a new page exactly in the cycle in which the Nth copy strobe is due. It does this once with a valid page, where the copy must vanish and the next write must be index 0 of the new base after the full delay. It does it once with a refused page, where the copy and every later slot must continue unchanged. A reference schedule in the bench gives the expected strobe, addresses and data for every cycle, so a displaced slot, a lost byte or a late busy edge is seen in the cycle it happens.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

   localparam int unsigned ADDR_W = 16;
   localparam int unsigned PAGE_W = 8;
   localparam int unsigned DATA_W = 8;

   function automatic logic page_allowed(input logic [PAGE_W-1:0] page,
                                         input logic [PAGE_W-1:0] limit);
      return page <= limit;
   endfunction

endpackage

// File: rtl/oam_dma_pacer.sv
module oam_dma_pacer #(
   parameter int unsigned START_DELAY = 8,
   parameter int unsigned INTERVAL    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   output logic fire
);
   localparam int unsigned MAX_GAP = (START_DELAY > INTERVAL) ? START_DELAY : INTERVAL;
   localparam int unsigned CW      = $clog2(MAX_GAP);

   if (START_DELAY < 2 || INTERVAL < 2) begin : g_bad_timing
      $error("oam_dma_pacer: START_DELAY and INTERVAL must be at least 2");
   end

   logic [CW-1:0] ctr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr <= '0;
      end else if (restart) begin
         ctr <= CW'(START_DELAY - 1);
      end else if (fire) begin
         ctr <= CW'(INTERVAL - 1);
      end else if (active && ctr != '0) begin
         ctr <= ctr - 1'b1;
      end
   end

   assign fire = active && (ctr == '0);

   // R4: two copy slots are never adjacent
   assert_slot_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !restart |=> !fire);

   // R3: a fresh start never yields a slot on the next cycle
   assert_start_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !fire);

endmodule

// File: rtl/oam_dma_tracker.sv
module oam_dma_tracker #(
   parameter int unsigned BYTES            = 160,
   parameter int unsigned AW               = 16,
   parameter int unsigned IW               = 8,
   parameter bit          COUNT_FROM_INDEX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          step,
   output logic [AW-1:0] src,
   output logic [IW-1:0] idx,
   output logic          busy
);
   localparam logic [IW-1:0] LAST_IDX = IW'(BYTES - 1);

   if (BYTES < 1 || BYTES > (1 << IW)) begin : g_bad_size
      $error("oam_dma_tracker: BYTES must fit the index width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src <= '0;
         idx <= '0;
      end else if (load) begin
         src <= base;
         idx <= '0;
      end else if (step) begin
         src <= src + 1'b1;
         idx <= idx + 1'b1;
      end
   end

   if (COUNT_FROM_INDEX) begin : g_flag
      logic run;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run <= 1'b0;
         end else if (load) begin
            run <= 1'b1;
         end else if (step && idx == LAST_IDX) begin
            run <= 1'b0;
         end
      end
      assign busy = run;
   end else begin : g_count
      localparam int unsigned CNW = $clog2(BYTES + 1);
      logic [CNW-1:0] left;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            left <= '0;
         end else if (load) begin
            left <= CNW'(BYTES);
         end else if (step) begin
            left <= left - 1'b1;
         end
      end
      assign busy = (left != '0);
   end

   // R5: a copy advances source and index by exactly one
   assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> (src == $past(src) + 1'b1) && (idx == $past(idx) + 1'b1));

   // R6: the copy at the last index ends the transfer
   assert_last_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && idx == LAST_IDX |=> !busy);

endmodule

// File: rtl/oam_copy_engine.sv
module oam_copy_engine
   import oam_dma_pkg::*;
#(
   parameter int unsigned        BYTES            = 160,
   parameter int unsigned        START_DELAY      = 8,
   parameter int unsigned        INTERVAL         = 4,
   parameter logic [PAGE_W-1:0]  PAGE_LIMIT       = 8'hF1,
   parameter bit                 COUNT_FROM_INDEX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [7:0]        wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o
);
   localparam int unsigned IW  = 8;
   localparam int unsigned LOW = ADDR_W - PAGE_W;

   if (ADDR_W <= PAGE_W) begin : g_bad_addr
      $error("oam_copy_engine: address must be wider than the page");
   end

   logic              accept;
   logic [ADDR_W-1:0] base;
   logic              fire;
   logic              step;
   logic [ADDR_W-1:0] src;
   logic [IW-1:0]     idx;
   logic              busy;

   assign accept = start_i && page_allowed(page_i, PAGE_LIMIT);
   assign base   = {page_i, {LOW{1'b0}}};
   assign step   = fire && !accept;

   oam_dma_pacer #(
      .START_DELAY (START_DELAY),
      .INTERVAL    (INTERVAL)
   ) i_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .active  (busy),
      .fire    (fire)
   );

   oam_dma_tracker #(
      .BYTES            (BYTES),
      .AW               (ADDR_W),
      .IW               (IW),
      .COUNT_FROM_INDEX (COUNT_FROM_INDEX)
   ) i_tracker (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .base  (base),
      .step  (step),
      .src   (src),
      .idx   (idx),
      .busy  (busy)
   );

   assign rd_en_o   = step;
   assign rd_addr_o = src;
   assign wr_en_o   = step;
   assign wr_addr_o = idx;
   assign wr_data_o = rd_data_i;
   assign busy_o    = busy;

   // R8: no write outside a transfer
   assert_write_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o);

   // R2: an accepted start loads base, clears the index and raises busy
   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o && (wr_addr_o == '0) && (rd_addr_o == $past(base)));

   // R1: a refused page leaves an idle engine idle
   assert_refused_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !page_allowed(page_i, PAGE_LIMIT) && !busy_o |=> !busy_o);

endmodule

// File: tb/test_oam_copy_engine.sv
module test_oam_copy_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NBYTES     = 160;
   localparam int LAST_OFS   = 7 + 4 * (NBYTES - 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  page_i = 8'h00;
   logic        rd_en_o;
   logic [15:0] rd_addr_o;
   logic [7:0]  rd_data_i;
   logic        wr_en_o;
   logic [7:0]  wr_addr_o;
   logic [7:0]  wr_data_o;
   logic        busy_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [7:0] bus_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign rd_data_i = bus_byte(rd_addr_o);

   oam_copy_engine i_oam_copy_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .page_i    (page_i),
      .rd_en_o   (rd_en_o),
      .rd_addr_o (rd_addr_o),
      .rd_data_i (rd_data_i),
      .wr_en_o   (wr_en_o),
      .wr_addr_o (wr_addr_o),
      .wr_data_o (wr_data_o),
      .busy_o    (busy_o)
   );

   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   bit          mon_on = 1'b0;
   bit          act = 1'b0;
   int          s_edge = 0;
   logic [15:0] base = 16'h0000;
   logic [7:0]  oam [NBYTES];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act_v, exp_v);
      end
   endtask

   // per-cycle reference schedule
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (mon_on) begin
            int  d;
            int  k;
            bit  exp_wr;
            bit  exp_busy;
            bit  coll;
            d        = cyc - s_edge - 7;
            coll     = start_i && (page_i <= 8'hF1);
            exp_wr   = act && d >= 0 && (d % 4) == 0 && (d / 4) < NBYTES && !coll;
            exp_busy = act && cyc >= s_edge && cyc <= s_edge + LAST_OFS;
            k        = exp_wr ? d / 4 : 0;
            if (coll && act && d >= 0 && (d % 4) == 0 && (d / 4) < NBYTES)
               check(wr_en_o == 1'b0, "R9 dropped copy", wr_en_o, 0);
            else if (k == 0)
               check(wr_en_o == exp_wr, "R3 strobe", wr_en_o, exp_wr);
            else
               check(wr_en_o == exp_wr, "R4 strobe", wr_en_o, exp_wr);
            check(rd_en_o == wr_en_o, "R5 read strobe", rd_en_o, wr_en_o);
            check(busy_o == exp_busy, "R8 R1 busy", busy_o, exp_busy);
            if (exp_wr) begin
               check(wr_addr_o == 8'(k), "R5 index", wr_addr_o, k);
               check(rd_addr_o == base + 16'(k), "R5 source", rd_addr_o, base + 16'(k));
               check(wr_data_o == bus_byte(base + 16'(k)), "R5 data", wr_data_o,
                     bus_byte(base + 16'(k)));
            end
            if (wr_en_o) oam[wr_addr_o] = wr_data_o;
         end
      end
   end

   task automatic kick(input logic [7:0] pg);
      start_i = 1'b1;
      page_i  = pg;
      @(posedge clk);
      #1;
      if (pg <= 8'hF1) begin
         act    = 1'b1;
         s_edge = cyc;
         base   = {pg, 8'h00};
      end
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(busy_o == 1'b0, "R8 reset busy", busy_o, 0);
      check(wr_en_o == 1'b0, "R8 reset write", wr_en_o, 0);
      mon_on = 1'b1;

      // R1: refused page while idle
      @(negedge clk);
      kick(8'hF2);
      #2;
      check(busy_o == 1'b0, "R1 refused page", busy_o, 0);
      repeat (20) @(negedge clk);

      // R2 R6: full transfer, then memory image
      kick(8'hC0);
      #2;
      check(busy_o == 1'b1 && rd_addr_o == 16'hC000 && wr_addr_o == 8'h00,
            "R2 load", {busy_o, rd_addr_o}, {1'b1, 16'hC000});
      wait_idle();
      for (int i = 0; i < NBYTES; i++)
         check(oam[i] == bus_byte(16'hC000 + 16'(i)), "R6 image", oam[i],
               bus_byte(16'hC000 + 16'(i)));

      // R1: boundary page accepted
      kick(8'hF1);
      #2;
      check(busy_o == 1'b1 && rd_addr_o == 16'hF100, "R1 boundary page", rd_addr_o, 16'hF100);
      wait_idle();

      // R7: restart mid-transfer
      kick(8'h12);
      wait_until(s_edge + 50);
      kick(8'h34);
      wait_until(s_edge + 7);
      #2;
      check(wr_en_o == 1'b1 && wr_addr_o == 8'h00 && rd_addr_o == 16'h3400,
            "R7 restart first byte", rd_addr_o, 16'h3400);
      wait_idle();

      // R9: valid start in a copy cycle
      kick(8'h80);
      wait_until(s_edge + 7 + 4 * 10);
      kick(8'h56);
      wait_idle();

      // R9: refused start in a copy cycle
      kick(8'h40);
      wait_until(s_edge + 7 + 4 * 5);
      kick(8'hFF);
      wait_idle();

      // R1: refused page while busy leaves the run intact
      kick(8'h07);
      wait_until(s_edge + 30);
      kick(8'hF9);
      wait_idle();

      mon_on = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule